// File: doc/BRIEF.md
# High-Side Switch Power Mode Sequencer

This block decides which power mode a high-side switch channel is in: normal (output may conduct), plain standby (bias and diagnostics off, lowest consumption), or standby with diagnostics (bias kept up so off-state open-load and short-to-battery sensing stays active). It watches the channel command, the diagnostic request and a supply undervoltage flag. The flag comes from an external comparator that already applies hysteresis. From these inputs it drives a mode code, bias and diagnostic enables, and a gate permit for the output driver.

A command that drops low does not send the channel to standby at once. The sequencer stays in normal mode with the gate permit withdrawn and counts 1 µs tick pulses. It leaves only after the command has stayed low for a parameterized number of ticks, 12500 by default, which is 12.5 ms. The standby variant it enters follows the diagnostic request at that moment. After that, changes on the diagnostic request move the channel between the two standby variants. An undervoltage shuts the gate immediately and parks the machine in plain standby until the supply recovers.

Top module: `hss_power_mode_seq`

## Requirements
- R1: Synchronous reset puts the mode code at plain standby (2'b00) and holds bias, diagnostic and gate enables low, whatever the command inputs are.
- R2: From either standby variant, with no undervoltage, a high command selects normal mode (2'b10) at the next clock edge.
- R3: The gate permit is high only in normal mode while the command is high and undervoltage is low. It follows a falling command in the same cycle and is low in both standby variants.
- R4: In normal mode with the command low, the mode changes at the clock edge that samples the DEGLITCH_TICKS-th tick pulse of the low period, and not before.
- R5: A command that returns high before the deglitch count completes keeps normal mode. Each new low period needs a full DEGLITCH_TICKS ticks.
- R6: On deglitch expiry, the target is standby with diagnostics (2'b01) if the diagnostic request is high in that cycle, otherwise plain standby (2'b00).
- R7: With the command low, plain standby moves to standby with diagnostics on the edge after the diagnostic request goes high, and the reverse happens on the edge after it goes low.
- R8: Bias is enabled in normal mode and in standby with diagnostics, and disabled in plain standby. The diagnostic enable is high in standby with diagnostics, and in normal mode whenever the diagnostic request is high.
- R9: Undervoltage drops the gate permit in the same cycle and forces plain standby from the next edge for as long as it lasts. Once it clears, the next mode is chosen from the levels of the command and the diagnostic request.
- R10: Only cycles with the tick input high advance the deglitch count. A low command with no ticks keeps normal mode indefinitely, and irregular tick spacing still needs exactly DEGLITCH_TICKS ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_1us_i | input | 1 | One-cycle pulse per microsecond, advances the deglitch count |
| in_req_i | input | 1 | Channel on command |
| diag_req_i | input | 1 | Diagnostic request |
| uv_i | input | 1 | Supply undervoltage flag, hysteresis already applied |
| mode_o | output | 2 | Mode code: 00 standby, 01 standby with diagnostics, 10 normal |
| bias_en_o | output | 1 | Bias circuit enable |
| diag_en_o | output | 1 | Diagnostic circuit enable |
| gate_en_o | output | 1 | Gate drive permit |

## Verification
The bench shortens the deglitch to four ticks. It sweeps every glitch length from zero up to one tick short of expiry, with each value of the diagnostic request. A counter that fires one tick early or late, or that keeps its count across a glitch instead of restarting, shows up as a wrong mode in one of those cycles. It flips the diagnostic request on the very tick that expires, which catches a design that latched the standby target early. It spaces ticks unevenly and also holds the command low with no ticks, so a design that counts clock cycles instead of ticks is caught. It raises undervoltage while the gate is on and during a deglitch, then releases it under each input combination. This exposes a gate that drops one cycle late or a recovery that ignores the sampled levels.

// File: rtl/hss_pm_pkg.sv
package hss_pm_pkg;

    typedef enum logic [1:0] {
        PM_STBY      = 2'b00,
        PM_STBY_DIAG = 2'b01,
        PM_NORMAL    = 2'b10
    } pm_mode_e;

    typedef struct packed {
        logic bias;
        logic diag;
        logic gate;
    } pm_en_t;

    // Standby flavour chosen by the diagnostic request level.
    function automatic pm_mode_e standby_for(input logic diag);
        return diag ? PM_STBY_DIAG : PM_STBY;
    endfunction

endpackage

// File: rtl/hss_pm_deglitch.sv
module hss_pm_deglitch
    import hss_pm_pkg::*;
#(
    parameter int unsigned LIMIT = 12500
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic run_i,
    output logic expire_o
);

    generate
        if (LIMIT <= 1) begin : g_single
            // A single tick ends the low period: no count needed.
            assign expire_o = run_i && tick_i;
        end else begin : g_count
            localparam int CW = $clog2(LIMIT);
            localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk_i) begin
                if (rst_i || !run_i) begin
                    cnt_q <= '0;
                end else if (tick_i && (cnt_q != LAST)) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign expire_o = run_i && tick_i && (cnt_q == LAST);

            // R10: a cycle without a tick leaves the count where it was
            assert_hold_without_tick_R10: assert property (@(posedge clk_i) disable iff (rst_i)
                (run_i && !tick_i) |=> (!run_i || $stable(cnt_q)));
            // R5: a new low period begins from an empty count
            assert_restart_on_release_R5: assert property (@(posedge clk_i) disable iff (rst_i)
                (!run_i) |=> (cnt_q == '0));
        end
    endgenerate

endmodule

// File: rtl/hss_pm_fsm.sv
module hss_pm_fsm
    import hss_pm_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     in_req_i,
    input  logic     diag_req_i,
    input  logic     uv_i,
    input  logic     expire_i,
    output pm_mode_e mode_o
);

    pm_mode_e mode_q;
    pm_mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        if (uv_i) begin
            mode_d = PM_STBY;
        end else begin
            unique case (mode_q)
                PM_NORMAL: begin
                    if (expire_i) mode_d = standby_for(diag_req_i);
                end
                PM_STBY: begin
                    if (in_req_i)        mode_d = PM_NORMAL;
                    else if (diag_req_i) mode_d = PM_STBY_DIAG;
                end
                PM_STBY_DIAG: begin
                    if (in_req_i)         mode_d = PM_NORMAL;
                    else if (!diag_req_i) mode_d = PM_STBY;
                end
                default: mode_d = PM_STBY;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) mode_q <= PM_STBY;
        else       mode_q <= mode_d;
    end

    assign mode_o = mode_q;

    assert_uv_forces_stby_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        uv_i |=> (mode_q == PM_STBY));
    assert_wake_on_command_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!uv_i && in_req_i && mode_q != PM_NORMAL) |=> (mode_q == PM_NORMAL));
    assert_stay_normal_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!uv_i && in_req_i && mode_q == PM_NORMAL) |=> (mode_q == PM_NORMAL));
    assert_no_early_exit_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (!uv_i && !expire_i && mode_q == PM_NORMAL) |=> (mode_q == PM_NORMAL));
    assert_stby_to_diag_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!uv_i && !in_req_i && diag_req_i && mode_q == PM_STBY) |=> (mode_q == PM_STBY_DIAG));

endmodule

// File: rtl/hss_pm_decode.sv
module hss_pm_decode
    import hss_pm_pkg::*;
(
    input  pm_mode_e mode_i,
    input  logic     in_req_i,
    input  logic     diag_req_i,
    input  logic     uv_i,
    output pm_en_t   en_o
);

    always_comb begin
        en_o = '0;
        unique case (mode_i)
            PM_NORMAL: begin
                en_o.bias = 1'b1;
                en_o.diag = diag_req_i;
                en_o.gate = in_req_i && !uv_i;
            end
            PM_STBY_DIAG: begin
                en_o.bias = 1'b1;
                en_o.diag = 1'b1;
            end
            default: en_o = '0;
        endcase
    end

endmodule

// File: rtl/hss_power_mode_seq.sv
module hss_power_mode_seq
    import hss_pm_pkg::*;
#(
    parameter int unsigned DEGLITCH_TICKS = 12500
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       tick_1us_i,
    input  logic       in_req_i,
    input  logic       diag_req_i,
    input  logic       uv_i,
    output logic [1:0] mode_o,
    output logic       bias_en_o,
    output logic       diag_en_o,
    output logic       gate_en_o
);

    pm_mode_e mode;
    pm_en_t   en;
    logic     run;
    logic     expire;

    // Count only while normal mode sees a low command and a healthy supply.
    assign run = (mode == PM_NORMAL) && !in_req_i && !uv_i;

    hss_pm_deglitch #(.LIMIT(DEGLITCH_TICKS)) u_deglitch (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .tick_i   (tick_1us_i),
        .run_i    (run),
        .expire_o (expire)
    );

    hss_pm_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .in_req_i   (in_req_i),
        .diag_req_i (diag_req_i),
        .uv_i       (uv_i),
        .expire_i   (expire),
        .mode_o     (mode)
    );

    hss_pm_decode u_decode (
        .mode_i     (mode),
        .in_req_i   (in_req_i),
        .diag_req_i (diag_req_i),
        .uv_i       (uv_i),
        .en_o       (en)
    );

    assign mode_o    = mode;
    assign bias_en_o = en.bias;
    assign diag_en_o = en.diag;
    assign gate_en_o = en.gate;

    assert_diag_needs_bias_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        diag_en_o |-> bias_en_o);
    assert_gate_off_in_uv_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        uv_i |-> !gate_en_o);
    assert_gate_only_normal_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        gate_en_o |-> (mode_o == 2'b10));

endmodule

// File: tb/hss_power_mode_seq_test.sv
`timescale 1ns/1ps
module hss_power_mode_seq_test;

    localparam int LIM = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic in_r = 1'b0;
    logic dg = 1'b0;
    logic uv = 1'b0;
    logic [1:0] mode;
    logic bias, den, gate;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    hss_power_mode_seq #(.DEGLITCH_TICKS(LIM)) uut (
        .clk_i      (clk),
        .rst_i      (rst),
        .tick_1us_i (tick),
        .in_req_i   (in_r),
        .diag_req_i (dg),
        .uv_i       (uv),
        .mode_o     (mode),
        .bias_en_o  (bias),
        .diag_en_o  (den),
        .gate_en_o  (gate)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Enables expected per R8 and R3 from the expected mode and the inputs.
    task automatic chk(input string req, input logic [1:0] em);
        logic eb, ed, eg;
        eb = (em == 2'b10) || (em == 2'b01);
        ed = (em == 2'b01) || ((em == 2'b10) && dg);
        eg = (em == 2'b10) && in_r && !uv;
        checks++;
        if ({mode, bias, den, gate} !== {em, eb, ed, eg}) begin
            errors++;
            $display("FAIL %s: got mode=%b bias=%b diag=%b gate=%b, expected mode=%b bias=%b diag=%b gate=%b",
                     req, mode, bias, den, gate, em, eb, ed, eg);
        end
    endtask

    task automatic tick_once();
        tick = 1'b1; cyc(1);
        tick = 1'b0; cyc(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset dominates even with the command and the request high
        in_r = 1'b1; dg = 1'b1;
        cyc(3);
        chk("R1", 2'b00);
        in_r = 1'b0; dg = 1'b0;
        cyc(1);
        rst = 1'b0;
        cyc(1);
        chk("R1", 2'b00);

        // R7: moves between the standby variants
        dg = 1'b1; cyc(1); chk("R7", 2'b01);
        dg = 1'b0; cyc(1); chk("R7", 2'b00);

        // R2: wake from both standby variants
        in_r = 1'b1; cyc(1); chk("R2", 2'b10);
        in_r = 1'b0; dg = 1'b1;
        repeat (LIM) tick_once();
        chk("R6", 2'b01);
        in_r = 1'b1; cyc(1); chk("R2", 2'b10);

        // R4 R5 R6 sweep over glitch length and request level
        for (int d = 0; d < 2; d++) begin
            for (int g = 0; g < LIM; g++) begin
                in_r = 1'b1; dg = d[0]; cyc(1);
                chk("R2", 2'b10);
                in_r = 1'b0; #1;
                chk("R3", 2'b10);
                repeat (g) tick_once();
                chk("R5", 2'b10);
                in_r = 1'b1; cyc(1);
                chk("R5", 2'b10);
                in_r = 1'b0;
                for (int k = 1; k <= LIM; k++) begin
                    tick_once();
                    if (k < LIM) chk("R4", 2'b10);
                    else         chk("R6", d ? 2'b01 : 2'b00);
                end
            end
        end

        // R6: request changes on the expiring tick
        in_r = 1'b1; dg = 1'b0; cyc(1); chk("R2", 2'b10);
        in_r = 1'b0;
        repeat (LIM - 1) tick_once();
        dg = 1'b1;
        tick_once();
        chk("R6", 2'b01);
        in_r = 1'b1; cyc(1);
        in_r = 1'b0; dg = 1'b1;
        repeat (LIM - 1) tick_once();
        dg = 1'b0; #1;
        chk("R8", 2'b10);
        tick_once();
        chk("R6", 2'b00);

        // R10: no ticks, then sparse ticks
        in_r = 1'b1; cyc(1);
        in_r = 1'b0; cyc(50);
        chk("R10", 2'b10);
        for (int k = 1; k <= LIM; k++) begin
            tick = 1'b1; cyc(1); tick = 1'b0; cyc(k + 2);
            chk("R10", (k < LIM) ? 2'b10 : 2'b00);
        end

        // R8: diagnostic enable follows the request in normal mode
        in_r = 1'b1; cyc(1);
        dg = 1'b1; #1; chk("R8", 2'b10);
        dg = 1'b0; #1; chk("R8", 2'b10);

        // R9: undervoltage handling
        dg = 1'b1; cyc(1);
        uv = 1'b1; #1;
        chk("R9", 2'b10);
        cyc(1); chk("R9", 2'b00);
        cyc(5); chk("R9", 2'b00);
        uv = 1'b0; in_r = 1'b0; cyc(1);
        chk("R9", 2'b01);
        uv = 1'b1; cyc(1); chk("R9", 2'b00);
        uv = 1'b0; in_r = 1'b1; cyc(1);
        chk("R9", 2'b10);
        in_r = 1'b0; dg = 1'b0;
        tick_once(); tick_once();
        uv = 1'b1; cyc(1); chk("R9", 2'b00);
        uv = 1'b0; cyc(1); chk("R9", 2'b00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule